// File: doc/BRIEF.md
# Page access permission evaluator

This unit decides whether one translated memory access may go ahead. It takes the protection state of the page and the segment it hits, plus the two class-key mask registers, and works out a read/write/execute permission set. Three separate sources each grant or withhold rights, and the result is their AND:
- a per-page no-execute/guard check;
- a storage-protection table indexed by the effective key and a 3-bit protection code;
- a class-key mask that the page's class key indexes.

When the access needs a right the result lacks, the unit raises a fault and reports which sources caused it. When the access is granted, it raises strobes that ask the page-table walker to set the page's referenced and changed bits. The unit does not perform those memory writes itself.

Each request is presented for one cycle with `inValid` high. The result appears on the registered outputs on the next clock edge, qualified by `outValid`. In a cycle with no request, the fault, cause and strobe outputs read zero. The permission outputs then keep their last value.

Top module: `page_perm_eval`

## Requirements
- R1: A request with `inValid` high in cycle n produces `outValid` high in cycle n+1 with the result for that request. With no request, `outValid` is low and `fault`, all cause flags, `setRef` and `setChg` are low. After reset, all outputs are low.
- R2: The effective key is `keyUser` when `isUser` is 1 and `keySuper` otherwise. The protection code is {`ppHi`, `ppLo[1:0]`}, with `ppHi` as the MSB.
- R3: The protection table works as follows.
  - With effective key 0: codes 0, 1 and 2 give read/write/execute; codes 3 and 6 give read/execute; codes 4, 5 and 7 give nothing.
  - With effective key 1: code 2 gives read/write/execute; codes 1 and 3 give read/execute; codes 0, 4, 5, 6 and 7 give nothing.
- R4: If `noExec` or `guarded` is 1, execute is withheld. Read and write are not affected.
- R5: When `keyProtEn` is 1, the 2-bit field at bits [2*(NUM_KEYS-1-classKey)+1 : 2*(NUM_KEYS-1-classKey)] of `dataMask` is used. Its upper bit withholds write and its lower bit withholds read. When `keyProtEn` is 0, the mask registers have no effect.
- R6: When `keyProtEn` and `newMmu` are both 1, bit 2*(NUM_KEYS-1-classKey) of `fetchMask` withholds execute. When `newMmu` is 0, `fetchMask` has no effect.
- R7: The returned permission `permR`/`permW`/`permX` is the AND of the three sources. Access type 0 is a fetch and needs execute. Type 1 is a load and needs read. Type 2 is a store and needs write. Type 3 is reserved and behaves as a load. `fault` is 1 when the needed right is absent.
- R8: On a denied fetch, the cause flags are set as follows.
  - `causeGuard` is set if the no-execute/guard source withheld execute.
  - Otherwise, `causeProt` is set if the protection table withheld execute.
  - `causeMask` is set independently if the mask source withheld execute.
- R9: On a denied load or store:
  - `causeProt` is set if the protection table lacks the needed right.
  - `causeMask` is set if the mask source lacks it.
  - `causeStore` is set for a store.
  - `causeGuard` is 0.
- R10: On a granted access:
  - `setRef` is 1 when `refBit` is 0.
  - When `chgBit` is 0, a store sets `setChg`, while any other access clears `permW` in the returned permission.
  - On a denied access, `setRef` and `setChg` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Request present this cycle |
| accType | input | 2 | 0 fetch, 1 load, 2 store, 3 reserved (load) |
| isUser | input | 1 | Access made in user state |
| keyUser | input | 1 | Segment key used for user accesses |
| keySuper | input | 1 | Segment key used for supervisor accesses |
| ppHi | input | 1 | Protection code MSB |
| ppLo | input | 2 | Protection code low bits |
| noExec | input | 1 | Page no-execute bit |
| guarded | input | 1 | Page guarded bit |
| classKey | input | KEY_BITS | Page class key |
| dataMask | input | 2*2^KEY_BITS | Class-key data access mask register |
| fetchMask | input | 2*2^KEY_BITS | Class-key instruction access mask register |
| keyProtEn | input | 1 | Class-key protection present |
| newMmu | input | 1 | One of the two newest MMU modes |
| refBit | input | 1 | Page referenced bit |
| chgBit | input | 1 | Page changed bit |
| outValid | output | 1 | Result valid |
| permR | output | 1 | Read permitted |
| permW | output | 1 | Write permitted |
| permX | output | 1 | Execute permitted |
| fault | output | 1 | Access denied |
| causeGuard | output | 1 | Fetch denied by no-execute/guard |
| causeProt | output | 1 | Denied by protection table |
| causeMask | output | 1 | Denied by class-key mask |
| causeStore | output | 1 | Denied access was a store |
| setRef | output | 1 | Request to set referenced bit |
| setChg | output | 1 | Request to set changed bit |

## Verification
The bench builds the block with the default KEY_BITS of 5. That gives 32 class keys and 64-bit mask registers, so the reversed field indexing can be probed at both ends. Key 0 selects the top field, bits 63:62, and key 31 selects the bottom field, bits 1:0. With the full-width masks, the bench also drives an unselected field to show that only the addressed pair matters. All eight protection codes are swept under both effective keys.

// File: rtl/page_perm_pkg.sv
package page_perm_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  // rights vector order: {read, write, execute}
  localparam int RIGHT_R = 2;
  localparam int RIGHT_W = 1;
  localparam int RIGHT_X = 0;

  typedef struct packed {
    logic capture;  // load a new result
    logic idle;     // clear event outputs
  } ctrl_t;
endpackage

// File: rtl/page_perm_ctrl.sv
module page_perm_ctrl
  import page_perm_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  inValid,
  output ctrl_t ctrl,
  output logic  outValid
);
  always_comb begin
    ctrl.capture = inValid;
    ctrl.idle    = ~inValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/page_perm_dp.sv
module page_perm_dp
  import page_perm_pkg::*;
#(
  parameter int KEY_BITS = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_t               ctrl,
  input  logic [1:0]          accType,
  input  logic                isUser,
  input  logic                keyUser,
  input  logic                keySuper,
  input  logic                ppHi,
  input  logic [1:0]          ppLo,
  input  logic                noExec,
  input  logic                guarded,
  input  logic [KEY_BITS-1:0] classKey,
  input  logic [2*(2**KEY_BITS)-1:0] dataMask,
  input  logic [2*(2**KEY_BITS)-1:0] fetchMask,
  input  logic                keyProtEn,
  input  logic                newMmu,
  input  logic                refBit,
  input  logic                chgBit,
  output logic                permR,
  output logic                permW,
  output logic                permX,
  output logic                fault,
  output logic                causeGuard,
  output logic                causeProt,
  output logic                causeMask,
  output logic                causeStore,
  output logic                setRef,
  output logic                setChg
);
  localparam int NUM_KEYS = 2**KEY_BITS;
  localparam int MASK_W   = 2*NUM_KEYS;
  localparam int IDX_W    = $clog2(MASK_W);

  logic             effKey;
  logic [2:0]       ppCode;
  logic [2:0]       tablePerm, guardPerm, maskPerm, allowed, needed, retPerm;
  logic [IDX_W-1:0] fieldLo;
  logic [1:0]       dataField;
  logic             fetchBit, isFetch, isStore, deny;
  logic             nGuard, nProt, nMask, nRef, nChg;

  always_comb begin
    effKey = isUser ? keyUser : keySuper;
    ppCode = {ppHi, ppLo};
    tablePerm = 3'b000;
    if (!effKey) begin
      unique case (ppCode)
        3'd0, 3'd1, 3'd2: tablePerm = 3'b111;
        3'd3, 3'd6:       tablePerm = 3'b101;
        default:          tablePerm = 3'b000;
      endcase
    end else begin
      unique case (ppCode)
        3'd2:       tablePerm = 3'b111;
        3'd1, 3'd3: tablePerm = 3'b101;
        default:    tablePerm = 3'b000;
      endcase
    end

    guardPerm = {2'b11, ~(noExec | guarded)};

    // reversed key order: key k owns pair at 2*(NUM_KEYS-1-k)
    fieldLo   = {~classKey, 1'b0};
    dataField = dataMask[fieldLo +: 2];
    fetchBit  = fetchMask[fieldLo];
    maskPerm  = 3'b111;
    if (keyProtEn) begin
      maskPerm[RIGHT_W] = ~dataField[1];
      maskPerm[RIGHT_R] = ~dataField[0];
      if (newMmu) maskPerm[RIGHT_X] = ~fetchBit;
    end

    allowed = tablePerm & guardPerm & maskPerm;
    isFetch = (accType == ACC_FETCH);
    isStore = (accType == ACC_STORE);
    unique case (accType)
      ACC_FETCH: needed = 3'b001;
      ACC_STORE: needed = 3'b010;
      default:   needed = 3'b100;
    endcase
    deny = |(needed & ~allowed);

    nGuard = 1'b0;
    nProt  = 1'b0;
    nMask  = 1'b0;
    if (deny) begin
      if (isFetch) begin
        nGuard = ~guardPerm[RIGHT_X];
        nProt  = guardPerm[RIGHT_X] & ~tablePerm[RIGHT_X];
        nMask  = ~maskPerm[RIGHT_X];
      end else begin
        nProt = |(needed & ~tablePerm);
        nMask = |(needed & ~maskPerm);
      end
    end

    nRef    = ~deny & ~refBit;
    nChg    = ~deny & ~chgBit & isStore;
    retPerm = allowed;
    if (!deny && !chgBit && !isStore) retPerm[RIGHT_W] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {permR, permW, permX} <= 3'b000;
      {fault, causeGuard, causeProt, causeMask, causeStore} <= 5'b0;
      {setRef, setChg} <= 2'b00;
    end else if (ctrl.capture) begin
      {permR, permW, permX} <= retPerm;
      fault      <= deny;
      causeGuard <= nGuard;
      causeProt  <= nProt;
      causeMask  <= nMask;
      causeStore <= deny & isStore;
      setRef     <= nRef;
      setChg     <= nChg;
    end else if (ctrl.idle) begin
      {fault, causeGuard, causeProt, causeMask, causeStore} <= 5'b0;
      {setRef, setChg} <= 2'b00;
    end
  end
endmodule

// File: rtl/page_perm_eval.sv
module page_perm_eval
  import page_perm_pkg::*;
#(
  parameter int KEY_BITS = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [1:0]          accType,
  input  logic                isUser,
  input  logic                keyUser,
  input  logic                keySuper,
  input  logic                ppHi,
  input  logic [1:0]          ppLo,
  input  logic                noExec,
  input  logic                guarded,
  input  logic [KEY_BITS-1:0] classKey,
  input  logic [2*(2**KEY_BITS)-1:0] dataMask,
  input  logic [2*(2**KEY_BITS)-1:0] fetchMask,
  input  logic                keyProtEn,
  input  logic                newMmu,
  input  logic                refBit,
  input  logic                chgBit,
  output logic                outValid,
  output logic                permR,
  output logic                permW,
  output logic                permX,
  output logic                fault,
  output logic                causeGuard,
  output logic                causeProt,
  output logic                causeMask,
  output logic                causeStore,
  output logic                setRef,
  output logic                setChg
);
  ctrl_t ctrl;

  page_perm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .ctrl(ctrl), .outValid(outValid)
  );

  page_perm_dp #(.KEY_BITS(KEY_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .accType(accType), .isUser(isUser),
    .keyUser(keyUser), .keySuper(keySuper), .ppHi(ppHi), .ppLo(ppLo),
    .noExec(noExec), .guarded(guarded), .classKey(classKey),
    .dataMask(dataMask), .fetchMask(fetchMask), .keyProtEn(keyProtEn),
    .newMmu(newMmu), .refBit(refBit), .chgBit(chgBit),
    .permR(permR), .permW(permW), .permX(permX), .fault(fault),
    .causeGuard(causeGuard), .causeProt(causeProt), .causeMask(causeMask),
    .causeStore(causeStore), .setRef(setRef), .setChg(setChg)
  );
endmodule

// File: rtl/page_perm_checker.sv
module page_perm_checker (
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic [1:0] accType,
  input logic       outValid,
  input logic       permX,
  input logic       fault,
  input logic       causeGuard,
  input logic       causeStore,
  input logic       setRef,
  input logic       setChg
);
  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rstN)
    outValid == $past(inValid));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> !(fault | setRef | setChg | causeStore | causeGuard));

  assert_guard_no_exec_R8: assert property (@(posedge clk) disable iff (!rstN)
    causeGuard |-> (fault && !permX));

  assert_store_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    causeStore |-> (fault && $past(accType) == 2'd2));

  assert_no_update_on_fault_R10: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> !(setRef || setChg));

  assert_chg_only_store_R10: assert property (@(posedge clk) disable iff (!rstN)
    setChg |-> ($past(inValid) && $past(accType) == 2'd2));
endmodule

bind page_perm_eval page_perm_checker u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .accType(accType),
  .outValid(outValid), .permX(permX), .fault(fault), .causeGuard(causeGuard),
  .causeStore(causeStore), .setRef(setRef), .setChg(setChg)
);

// File: tb/page_perm_eval_tb.sv
`timescale 1ns/1ps
module page_perm_eval_tb;
  localparam int KEY_BITS = 5;
  localparam int MASK_W = 2*(2**KEY_BITS);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [1:0] accType = 2'd1;
  logic isUser = 1'b0, keyUser = 1'b0, keySuper = 1'b0, ppHi = 1'b0;
  logic [1:0] ppLo = 2'd0;
  logic noExec = 1'b0, guarded = 1'b0;
  logic [KEY_BITS-1:0] classKey = '0;
  logic [MASK_W-1:0] dataMask = '0, fetchMask = '0;
  logic keyProtEn = 1'b0, newMmu = 1'b0, refBit = 1'b1, chgBit = 1'b1;
  logic outValid, permR, permW, permX, fault, causeGuard, causeProt, causeMask;
  logic causeStore, setRef, setChg;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  page_perm_eval #(.KEY_BITS(KEY_BITS)) u_dut (.*);

  task automatic chk(input string req, input string what, input logic [7:0] act,
                     input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic defaults();
    accType = 2'd1; isUser = 0; keyUser = 0; keySuper = 0; ppHi = 0; ppLo = 2'd2;
    noExec = 0; guarded = 0; classKey = '0; dataMask = '0; fetchMask = '0;
    keyProtEn = 0; newMmu = 0; refBit = 1; chgBit = 1;
  endtask

  // present one request; leave the clock at the negedge after the result edge
  task automatic fire();
    inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic setPp(input int code);
    ppHi = code[2];
    ppLo = code[1:0];
  endtask

  task automatic t_reset();
    chk("R1", "reset outValid", {7'd0, outValid}, 8'd0);
    chk("R1", "reset fault/strobes", {5'd0, fault, setRef, setChg}, 8'd0);
  endtask

  task automatic t_table();
    logic [7:0] r0 = 8'b0100_1111, w0 = 8'b0000_0111;
    logic [7:0] r1 = 8'b0000_1110, w1 = 8'b0000_0100;
    for (int k = 0; k < 2; k++) begin
      for (int c = 0; c < 8; c++) begin
        defaults(); keySuper = k[0]; setPp(c); accType = 2'd1;
        fire();
        chk("R3", $sformatf("key%0d code%0d R", k, c), {7'd0, permR}, {7'd0, (k == 0) ? r0[c] : r1[c]});
        chk("R3", $sformatf("key%0d code%0d W", k, c), {7'd0, permW}, {7'd0, (k == 0) ? w0[c] : w1[c]});
        chk("R3", $sformatf("key%0d code%0d X", k, c), {7'd0, permX}, {7'd0, (k == 0) ? r0[c] : r1[c]});
        chk("R7", $sformatf("key%0d code%0d load fault", k, c), {7'd0, fault}, {7'd0, (k == 0) ? ~r0[c] : ~r1[c]});
      end
    end
  endtask

  task automatic t_keysel();
    defaults(); isUser = 1; keyUser = 1; keySuper = 0; setPp(0); accType = 2'd2;
    fire();
    chk("R2", "user picks user key: fault", {7'd0, fault}, 8'd1);
    defaults(); isUser = 0; keyUser = 1; keySuper = 0; setPp(0); accType = 2'd2;
    fire();
    chk("R2", "super picks super key: fault", {7'd0, fault}, 8'd0);
    defaults(); ppHi = 1; ppLo = 2'd2; keySuper = 0; accType = 2'd1;  // code 6, key0 -> r/x
    fire();
    chk("R2", "pp MSB is ppHi: perms", {5'd0, permR, permW, permX}, 8'b101);
  endtask

  task automatic t_guard();
    defaults(); noExec = 1; accType = 2'd0;
    fire();
    chk("R4", "noexec fetch perms", {5'd0, permR, permW, permX}, 8'b110);
    chk("R8", "noexec fetch causes", {4'd0, fault, causeGuard, causeProt, causeMask}, 8'b1100);
    defaults(); guarded = 1; accType = 2'd1;
    fire();
    chk("R4", "guarded load ok", {6'd0, fault, permR}, 8'b01);
  endtask

  task automatic t_mask();
    defaults(); keyProtEn = 1; classKey = 5'd0; dataMask[63] = 1'b1; accType = 2'd2;
    fire();
    chk("R5", "key0 store denied causes", {3'd0, fault, causeGuard, causeProt, causeMask, causeStore}, 8'b10011);
    defaults(); keyProtEn = 1; classKey = 5'd0; dataMask[63] = 1'b1; accType = 2'd1;
    fire();
    chk("R5", "key0 load allowed perms", {4'd0, fault, permR, permW, permX}, 8'b0101);
    defaults(); keyProtEn = 1; classKey = 5'd31; dataMask[0] = 1'b1; accType = 2'd1;
    fire();
    chk("R9", "key31 load denied causes", {4'd0, fault, causeProt, causeMask, causeStore}, 8'b1010);
    defaults(); keyProtEn = 1; classKey = 5'd31; dataMask[62] = 1'b1; accType = 2'd1;
    fire();
    chk("R5", "other field ignored", {7'd0, fault}, 8'd0);
    defaults(); keyProtEn = 0; dataMask = '1; fetchMask = '1; newMmu = 1; accType = 2'd2;
    fire();
    chk("R5", "masks off: store granted rwx", {4'd0, fault, permR, permW, permX}, 8'b0111);
  endtask

  task automatic t_fetchmask();
    defaults(); keyProtEn = 1; newMmu = 1; classKey = 5'd3; fetchMask[56] = 1'b1; accType = 2'd0;
    fire();
    chk("R6", "fetch mask denies", {4'd0, fault, causeGuard, causeProt, causeMask}, 8'b1001);
    defaults(); keyProtEn = 1; newMmu = 0; classKey = 5'd3; fetchMask[56] = 1'b1; accType = 2'd0;
    fire();
    chk("R6", "old mmu ignores fetch mask", {6'd0, fault, permX}, 8'b01);
    defaults(); keyProtEn = 1; newMmu = 1; classKey = 5'd3; fetchMask[57] = 1'b1; accType = 2'd0;
    fire();
    chk("R6", "upper fetch bit unused", {7'd0, fault}, 8'd0);
  endtask

  task automatic t_fetchcause();
    defaults(); keySuper = 1; setPp(0); noExec = 1; accType = 2'd0;
    fire();
    chk("R8", "guard wins over prot", {5'd0, causeGuard, causeProt, causeMask}, 8'b100);
    defaults(); keySuper = 1; setPp(0); keyProtEn = 1; newMmu = 1; fetchMask[62] = 1; accType = 2'd0;
    fire();
    chk("R8", "prot plus mask", {4'd0, fault, causeGuard, causeProt, causeMask}, 8'b1011);
    defaults(); keySuper = 1; setPp(1); keyProtEn = 1; dataMask[63:62] = 2'b11; accType = 2'd2;
    fire();
    chk("R9", "store prot+mask+store", {3'd0, fault, causeGuard, causeProt, causeMask, causeStore}, 8'b10111);
  endtask

  task automatic t_refchg();
    defaults(); refBit = 0; chgBit = 0; accType = 2'd1;
    fire();
    chk("R10", "load R=0 C=0", {3'd0, fault, setRef, setChg, permW, permR}, 8'b01001);
    defaults(); refBit = 1; chgBit = 0; accType = 2'd2;
    fire();
    chk("R10", "store C=0", {3'd0, fault, setRef, setChg, permW, permR}, 8'b00111);
    defaults(); refBit = 0; chgBit = 0; keySuper = 1; setPp(3); accType = 2'd2;
    fire();
    chk("R10", "denied store no strobes", {5'd0, fault, setRef, setChg}, 8'b100);
    defaults(); refBit = 0; chgBit = 1; accType = 2'd0;
    fire();
    chk("R10", "fetch R=0 C=1", {4'd0, setRef, setChg, permW, permX}, 8'b1011);
  endtask

  task automatic t_reserved();
    defaults(); keyProtEn = 1; dataMask[62] = 1'b1; accType = 2'd3;
    fire();
    chk("R7", "reserved type acts as load", {5'd0, fault, causeMask, causeStore}, 8'b110);
  endtask

  task automatic t_idle();
    defaults(); refBit = 0; chgBit = 0; accType = 2'd2;
    fire();
    chk("R1", "result cycle valid", {6'd0, outValid, setChg}, 8'b11);
    @(negedge clk);
    chk("R1", "idle cycle quiet", {4'd0, outValid, fault, setRef, setChg}, 8'b0000);
  endtask

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_table();
    t_keysel();
    t_guard();
    t_mask();
    t_fetchmask();
    t_fetchcause();
    t_refchg();
    t_reserved();
    t_idle();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule